// File: doc/BRIEF.md
# Four-Phase Handshake Register Bus Slave

This block sits on the programmable-logic side of a narrow parallel link to a microcontroller. The link has one 8-bit data path, split here into an input, an output and an output enable so that the pad can be placed outside. Four control lines come from the host: a start strobe, a read/write select, an active-low reset and a request handshake. The block answers on a busy line and a reply handshake line. Every control input is resynchronised to the local clock before any decision is taken on it.

A transaction opens with a start pulse. The host then writes six bytes, each under a fully interlocked four-phase handshake: an opcode, an 8-bit register number and a 32-bit value sent low byte first. The block runs one register operation on its internal register port, then serves eight reply bytes to the host: a 32-bit result word and a 32-bit status word, each sent low byte first. Register 0 is a constant system word held inside the block. A request handshake that arrives while the block is idle and no start has been seen is answered with a bare handshake cycle, so the host can probe the link without a reset.

Top module: `hsbus_slave`

## Requirements
- R1: While `link_rst_n` is low, and on the first clock edge after it is released, `busy_ack`, `reply_out` and `bus_oe` are all low.
- R2: Opcode 0x00 is a register write: exactly one `reg_wr` pulse is issued with `reg_addr` equal to the address byte and `reg_wdata` equal to bytes 2..5 of the request, byte 2 being least significant. The reply carries result word 0 and status 0.
- R3: Opcode 0x01 is a register read: exactly one `reg_rd` pulse is issued and the reply result word equals `reg_rdata` at that pulse. The eight reply bytes are the result word then the status word, each least significant byte first.
- R4: Register 0 reads as the parameter `SYS_WORD` with no `reg_rd` pulse. A write to register 0 returns status 3 and issues no `reg_wr`.
- R5: An address of `NUM_REGS` or more returns status 2 and result word 0, and issues no register strobe.
- R6: An opcode other than 0x00 or 0x01 returns status 1 and result word 0, and issues no register strobe.
- R7: `busy_ack` rises after a start pulse and stays high until the host has dropped its request at the end of the eighth reply byte. It then returns low.
- R8: `bus_oe` is high only during reply-byte phases, and it falls in the same cycle as `reply_out` falls.
- R9: On a request byte, `reply_out` rises only after `req_in` has been seen high, with the byte captured at that point. It falls only after `req_in` has been seen low.
- R10: On a reply byte, the data is driven before `reply_out` rises. `reply_out` falls only after `req_in` has been seen high.
- R11: A request handshake that arrives while idle with no start pulse raises `reply_out` until `req_in` falls. `busy_ack` stays low throughout and no register strobe is issued.
- R12: Pulling `link_rst_n` low in the middle of a frame abandons that frame with no register strobe. The next transaction completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| link_rst_n | input | 1 | Host reset, active low, asynchronous |
| start_in | input | 1 | Host start strobe, asynchronous |
| rd_sel_in | input | 1 | Host direction select, 1 = read from slave |
| req_in | input | 1 | Host request handshake, asynchronous |
| bus_in | input | 8 | Data byte from the host |
| bus_out | output | 8 | Data byte to the host |
| bus_oe | output | 1 | Output enable for the data pad |
| busy_ack | output | 1 | High while a transaction is in progress |
| reply_out | output | 1 | Slave reply handshake |
| reg_addr | output | 8 | Register port address |
| reg_wdata | output | 32 | Register port write data |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_rdata | input | 32 | Register read data, valid in the strobe cycle |

## Verification
The assertions rely on the host behaving as a handshake partner. A level change on `req_in` happens only after the host has seen the matching level on `reply_out`. The host holds `bus_in` and `rd_sel_in` stable from before it raises a request until the reply rises. Start pulses last at least two clock periods and do not overlap a frame. The bench host is written as a strict partner in exactly this sense: it waits on the sampled reply before every edge it makes. It changes direction only between bytes and holds start high for three cycles. Its peripheral model answers `reg_rdata` combinationally from the address.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int WORD_W    = 32;
    localparam int WORD_B    = WORD_W / BYTE_W;
    localparam int REQ_BYTES = 2 + WORD_B;
    localparam int RSP_BYTES = 2 * WORD_B;
    localparam int IDX_W     = $clog2(RSP_BYTES);

    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h00;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h01;

    localparam logic [WORD_W-1:0] STAT_OK        = 32'd0;
    localparam logic [WORD_W-1:0] STAT_BAD_OP    = 32'd1;
    localparam logic [WORD_W-1:0] STAT_BAD_ADDR  = 32'd2;
    localparam logic [WORD_W-1:0] STAT_READ_ONLY = 32'd3;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_PROBE,
        LK_RX_WAIT,
        LK_RX_ACK,
        LK_EXEC,
        LK_TX_WAIT,
        LK_TX_OFFER,
        LK_TX_DONE
    } link_state_e;

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q[s] <= '0;
                else         chain_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q[s] <= '0;
                else         chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hsb_exec.sv
module hsb_exec
    import hsb_pkg::*;
#(
    parameter int                NUM_REGS = 16,
    parameter logic [WORD_W-1:0] SYS_WORD = 32'h0001_0A21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic [WORD_W-1:0] res_data,
    output logic [WORD_W-1:0] res_status
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] status;
    } exec_t;

    exec_t st_d, st_q;

    logic              is_wr, is_rd, in_range, is_sys;
    logic [WORD_W-1:0] stat_c;
    logic [WORD_W-1:0] data_c;

    always_comb begin
        is_wr    = (op == OP_WRITE);
        is_rd    = (op == OP_READ);
        in_range = ({1'b0, addr} < LIMIT);
        is_sys   = (addr == '0);

        if (!is_wr && !is_rd)    stat_c = STAT_BAD_OP;
        else if (!in_range)      stat_c = STAT_BAD_ADDR;
        else if (is_wr && is_sys) stat_c = STAT_READ_ONLY;
        else                     stat_c = STAT_OK;

        if (is_rd && stat_c == STAT_OK) data_c = is_sys ? SYS_WORD : reg_rdata;
        else                            data_c = '0;

        reg_addr  = addr;
        reg_wdata = wdata;
        reg_wr    = go && is_wr && (stat_c == STAT_OK);
        reg_rd    = go && is_rd && (stat_c == STAT_OK) && !is_sys;

        st_d = st_q;
        if (go) begin
            st_d.data   = data_c;
            st_d.status = stat_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_data   = st_q.data;
    assign res_status = st_q.status;

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd}));

    // R4
    sys_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr != '0));

    // R5
    strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> ({1'b0, reg_addr} < LIMIT));

endmodule

// File: rtl/hsb_link_fsm.sv
module hsb_link_fsm
    import hsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_s,
    input  logic              rd_sel_s,
    input  logic              req_s,
    input  logic [BYTE_W-1:0] bus_in,
    input  logic [WORD_W-1:0] res_data,
    input  logic [WORD_W-1:0] res_status,
    output logic [BYTE_W-1:0] op,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata,
    output logic              go,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              busy,
    output logic              reply
);
    localparam logic [IDX_W-1:0] REQ_LAST = IDX_W'(REQ_BYTES - 1);
    localparam logic [IDX_W-1:0] RSP_LAST = IDX_W'(RSP_BYTES - 1);

    typedef struct packed {
        link_state_e                  state;
        logic [IDX_W-1:0]             idx;
        logic [REQ_BYTES*BYTE_W-1:0]  frame;
        logic [BYTE_W-1:0]            dout;
        logic                         oe;
        logic                         reply;
        logic                         busy;
        logic                         start_prev;
    } link_t;

    link_t lk_d, lk_q;

    logic [RSP_BYTES*BYTE_W-1:0] rsp_word;
    logic [BYTE_W-1:0]           rsp_byte;

    always_comb begin
        rsp_word = {res_status, res_data};
        rsp_byte = rsp_word[{lk_q.idx, 3'b000} +: BYTE_W];

        lk_d            = lk_q;
        lk_d.start_prev = start_s;

        case (lk_q.state)
            LK_IDLE: begin
                lk_d.busy  = 1'b0;
                lk_d.reply = 1'b0;
                lk_d.oe    = 1'b0;
                if (start_s && !lk_q.start_prev) begin
                    lk_d.busy  = 1'b1;
                    lk_d.idx   = '0;
                    lk_d.state = LK_RX_WAIT;
                end else if (req_s) begin
                    lk_d.reply = 1'b1;
                    lk_d.state = LK_PROBE;
                end
            end
            LK_PROBE: begin
                if (!req_s) begin
                    lk_d.reply = 1'b0;
                    lk_d.state = LK_IDLE;
                end
            end
            LK_RX_WAIT: begin
                if (req_s) begin
                    lk_d.frame[{lk_q.idx, 3'b000} +: BYTE_W] = bus_in;
                    lk_d.reply = 1'b1;
                    lk_d.state = LK_RX_ACK;
                end
            end
            LK_RX_ACK: begin
                if (!req_s) begin
                    lk_d.reply = 1'b0;
                    if (lk_q.idx == REQ_LAST) begin
                        lk_d.idx   = '0;
                        lk_d.state = LK_EXEC;
                    end else begin
                        lk_d.idx   = lk_q.idx + 1'b1;
                        lk_d.state = LK_RX_WAIT;
                    end
                end
            end
            LK_EXEC: begin
                lk_d.state = LK_TX_WAIT;
            end
            LK_TX_WAIT: begin
                if (rd_sel_s && !req_s) begin
                    lk_d.oe    = 1'b1;
                    lk_d.dout  = rsp_byte;
                    lk_d.state = LK_TX_OFFER;
                end
            end
            LK_TX_OFFER: begin
                if (!lk_q.reply) begin
                    lk_d.reply = 1'b1;
                end else if (req_s) begin
                    lk_d.reply = 1'b0;
                    lk_d.oe    = 1'b0;
                    lk_d.state = LK_TX_DONE;
                end
            end
            LK_TX_DONE: begin
                if (!req_s) begin
                    if (lk_q.idx == RSP_LAST) begin
                        lk_d.busy  = 1'b0;
                        lk_d.idx   = '0;
                        lk_d.state = LK_IDLE;
                    end else begin
                        lk_d.idx   = lk_q.idx + 1'b1;
                        lk_d.state = LK_TX_WAIT;
                    end
                end
            end
            default: lk_d.state = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{state: LK_IDLE, default: '0};
        else        lk_q <= lk_d;
    end

    assign op      = lk_q.frame[0 +: BYTE_W];
    assign addr    = lk_q.frame[BYTE_W +: ADDR_W];
    assign wdata   = lk_q.frame[2*BYTE_W +: WORD_W];
    assign go      = (lk_q.state == LK_EXEC);
    assign bus_out = lk_q.dout;
    assign bus_oe  = lk_q.oe;
    assign busy    = lk_q.busy;
    assign reply   = lk_q.reply;

    // R8
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_q.reply) |-> !lk_q.oe);

    // R8
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.oe |-> lk_q.busy);

    // R9
    rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lk_q.reply) && !lk_q.oe) |-> $past(req_s));

    // R9
    rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lk_q.reply) && !$past(lk_q.oe)) |-> !$past(req_s));

    // R10
    tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lk_q.reply) && $past(lk_q.oe)) |-> $past(req_s));

    // R10
    tx_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lk_q.reply) && lk_q.oe) |-> ($past(lk_q.oe) && $stable(lk_q.dout)));

endmodule

// File: rtl/hsbus_slave.sv
module hsbus_slave
    import hsb_pkg::*;
#(
    parameter int                NUM_REGS    = 16,
    parameter logic [WORD_W-1:0] SYS_WORD    = 32'h0001_0A21,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              link_rst_n,
    input  logic              start_in,
    input  logic              rd_sel_in,
    input  logic              req_in,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              busy_ack,
    output logic              reply_out,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic              rst_n_i;
    logic [2:0]        ctl_s;
    logic [BYTE_W-1:0] op;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic              go;
    logic [WORD_W-1:0] res_data, res_status;

    hsb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk    (clk),
        .arst_n (link_rst_n),
        .d      (1'b1),
        .q      (rst_n_i)
    );

    hsb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk    (clk),
        .arst_n (rst_n_i),
        .d      ({start_in, rd_sel_in, req_in}),
        .q      (ctl_s)
    );

    hsb_link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n_i),
        .start_s    (ctl_s[2]),
        .rd_sel_s   (ctl_s[1]),
        .req_s      (ctl_s[0]),
        .bus_in     (bus_in),
        .res_data   (res_data),
        .res_status (res_status),
        .op         (op),
        .addr       (addr),
        .wdata      (wdata),
        .go         (go),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .busy       (busy_ack),
        .reply      (reply_out)
    );

    hsb_exec #(.NUM_REGS(NUM_REGS), .SYS_WORD(SYS_WORD)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n_i),
        .go         (go),
        .op         (op),
        .addr       (addr),
        .wdata      (wdata),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .res_data   (res_data),
        .res_status (res_status)
    );

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
        (reg_wr || reg_rd) |-> busy_ack);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n_i |-> (!busy_ack && !reply_out && !bus_oe));

endmodule

// File: tb/sim_hsbus_slave.sv
`timescale 1ns/1ps
module sim_hsbus_slave;
    localparam int          NREG = 16;
    localparam logic [31:0] SYS  = 32'h0001_0A21;

    logic        clk = 1'b0;
    logic        link_rst_n = 1'b0;
    logic        start_in = 1'b0, rd_sel_in = 1'b0, req_in = 1'b0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_oe, busy_ack, reply_out;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd;

    int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, oe_bad = 0;
    logic [31:0] regs [NREG];

    always #10 clk = ~clk;

    hsbus_slave #(.NUM_REGS(NREG), .SYS_WORD(SYS), .SYNC_STAGES(2)) u0 (
        .clk(clk), .link_rst_n(link_rst_n), .start_in(start_in), .rd_sel_in(rd_sel_in),
        .req_in(req_in), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .busy_ack(busy_ack), .reply_out(reply_out), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = (reg_addr < NREG) ? regs[reg_addr[3:0]] : 32'hDEAD_0000;

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt <= wr_cnt + 1;
            if (reg_addr < NREG) regs[reg_addr[3:0]] <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) if (bus_oe && !rd_sel_in) oe_bad++;

    function automatic logic [31:0] pat(input int a);
        return (32'h9E37_79B9 * (a + 1)) ^ (32'(a) << 24);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_reply(input logic v);
        while (reply_out !== v) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        rd_sel_in = 1'b0;
        bus_in = b;
        @(negedge clk);
        req_in = 1'b1;
        wait_reply(1'b1);
        req_in = 1'b0;
        wait_reply(1'b0);
    endtask

    task automatic rd_byte(input bit last, output logic [7:0] b);
        rd_sel_in = 1'b1;
        wait_reply(1'b1);
        check("R10 oe with reply", {31'd0, bus_oe}, 32'd1);
        b = bus_out;
        req_in = 1'b1;
        wait_reply(1'b0);
        check("R8 oe drops with reply", {31'd0, bus_oe}, 32'd0);
        if (last) check("R7 busy before final release", {31'd0, busy_ack}, 32'd1);
        req_in = 1'b0;
    endtask

    task automatic txn(input logic [7:0] op, input logic [7:0] a, input logic [31:0] wd,
                       output logic [31:0] rdat, output logic [31:0] rst);
        logic [47:0] fr;
        logic [63:0] rsp;
        logic [7:0]  b;
        fr = {wd, a, op};
        @(negedge clk);
        start_in = 1'b1;
        repeat (3) @(negedge clk);
        start_in = 1'b0;
        for (int i = 0; i < 6; i++) begin
            wr_byte(fr[i*8 +: 8]);
            if (i == 0) check("R7 busy in frame", {31'd0, busy_ack}, 32'd1);
        end
        for (int i = 0; i < 8; i++) begin
            rd_byte(i == 7, b);
            rsp[i*8 +: 8] = b;
        end
        while (busy_ack !== 1'b0) @(negedge clk);
        rdat = rsp[31:0];
        rst  = rsp[63:32];
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d, s;
        int w0, r0;
        repeat (5) @(negedge clk);
        check("R1 busy in reset", {31'd0, busy_ack}, 32'd0);
        check("R1 reply in reset", {31'd0, reply_out}, 32'd0);
        check("R1 oe in reset", {31'd0, bus_oe}, 32'd0);
        repeat (995) @(negedge clk);
        link_rst_n = 1'b1;
        @(negedge clk);
        check("R1 quiet after reset", {29'd0, busy_ack, reply_out, bus_oe}, 32'd0);
        repeat (4) @(negedge clk);

        // R11 probe without start
        req_in = 1'b1;
        wait_reply(1'b1);
        check("R11 busy low in probe", {31'd0, busy_ack}, 32'd0);
        req_in = 1'b0;
        wait_reply(1'b0);
        repeat (4) @(negedge clk);
        check("R11 no strobe, idle", 32'(wr_cnt + rd_cnt) | {31'd0, busy_ack}, 32'd0);

        // R2 write sweep
        for (int a = 1; a < NREG; a++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            txn(8'h00, 8'(a), pat(a), d, s);
            check("R2 write status", s, 32'd0);
            check("R2 write data word", d, 32'd0);
            check("R2 one write strobe", 32'(wr_cnt - w0), 32'd1);
            check("R2 stored value", regs[a], pat(a));
        end

        // R3 / R4 read sweep
        for (int a = 0; a < NREG; a++) begin
            r0 = rd_cnt;
            txn(8'h01, 8'(a), 32'hFFFF_FFFF, d, s);
            check("R3 read status", s, 32'd0);
            check("R3 read data", d, (a == 0) ? SYS : pat(a));
            check("R4 read strobe count", 32'(rd_cnt - r0), (a == 0) ? 32'd0 : 32'd1);
        end

        // R4 write to system word
        w0 = wr_cnt;
        txn(8'h00, 8'h00, 32'h1234_5678, d, s);
        check("R4 read-only status", s, 32'd3);
        check("R4 no write strobe", 32'(wr_cnt - w0), 32'd0);
        txn(8'h01, 8'h00, 32'd0, d, s);
        check("R4 system word intact", d, SYS);

        // R5 out-of-range sweep
        for (int a = NREG; a < 256; a++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            txn(8'(a & 1), 8'(a), pat(a), d, s);
            check("R5 range status", s, 32'd2);
            check("R5 range data", d, 32'd0);
            check("R5 no strobe", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
        end

        // R6 unknown opcode sweep
        for (int c = 2; c < 256; c++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            txn(8'(c), 8'd5, 32'hA5A5_A5A5, d, s);
            check("R6 opcode status", s, 32'd1);
            check("R6 opcode data", d, 32'd0);
            check("R6 no strobe", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
        end
        txn(8'h01, 8'd5, 32'd0, d, s);
        check("R6 register untouched", d, pat(5));

        // R12 reset mid-frame
        w0 = wr_cnt;
        @(negedge clk);
        start_in = 1'b1;
        repeat (3) @(negedge clk);
        start_in = 1'b0;
        wr_byte(8'h00);
        wr_byte(8'd7);
        wr_byte(8'h11);
        link_rst_n = 1'b0;
        @(negedge clk);
        check("R12 quiet in reset", {29'd0, busy_ack, reply_out, bus_oe}, 32'd0);
        repeat (20) @(negedge clk);
        link_rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 no write strobe", 32'(wr_cnt - w0), 32'd0);
        txn(8'h01, 8'd7, 32'd0, d, s);
        check("R12 next status", s, 32'd0);
        check("R12 next data", d, pat(7));

        check("R8 oe only when reading", 32'(oe_bad), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule